// File: doc/BRIEF.md
# Register Rename History Buffer

This block keeps the ordered log of register renames for one instruction stream. Each time the rename stage gives a destination register a new physical register, it pushes one record into the log. A record holds a sequence number, an architectural register, the new physical register and the physical register that was mapped before it. Sequence numbers rise with program order and do not wrap. Records enter at the young end of a circular buffer.

Three operations remove records.

- **Commit:** retires the oldest records up to a given sequence number. For each one it hands the old physical register back to the free list.
- **Squash:** walks back from the youngest record. It removes every record newer than the squash point. For each one it writes the old mapping back into the rename map and frees the new register.
- **Flush:** undoes every record in the same way as a squash, until the log is empty.

Every walk removes one record per cycle. `busy` stays high while a walk is in progress. The block drives map-restore writes and free-list returns on registered outputs. It also keeps two running counts: one of undone records and one of committed records. The map and the free list themselves live outside the block.

Top module: `rename_history`

## Requirements
- R1: A push is stored at the young end when the buffer is not full and no squash or flush is requested or walking. `full` is high exactly when DEPTH records are held. A push while full is dropped and changes nothing.
- R2: A squash with sequence S, accepted at clock edge k, removes records whose sequence is greater than S, youngest first, one per cycle starting at edge k+1. Each removal gives, one edge later, `map_wr_valid` with the record's architectural register and previous physical register, together with `free_valid` carrying its new physical register.
- R3: A commit with sequence C, accepted at edge k, removes records whose sequence is at most C, oldest first, one per cycle starting at edge k+1. Each removal gives, one edge later, `free_valid` with the record's previous physical register and no map write.
- R4: A commit request is ignored in a cycle that also carries a squash or flush request, and while a squash or flush walk is active. A squash is ignored while a flush walk is active.
- R5: Squash and commit requests on an empty buffer produce no output. A commit older than the oldest record produces no output and leaves the contents unchanged.
- R6: A flush removes every record, youngest first, with the same outputs as a squash, and leaves the buffer empty.
- R7: `busy` is high from the edge that accepts a request until the edge after the walk finds nothing more to remove. No map write or free is issued unless `busy` was high in the previous cycle.
- R8: `undo_count` rises by one for each map-restore write, and `commit_count` rises by one for each commit-side free.
- R9: After reset the buffer is empty, `full`, `busy`, `map_wr_valid` and `free_valid` are low, and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Record push request |
| push_seq | input | SEQ_W | Sequence number of the pushed record |
| push_arch | input | ARCH_W | Architectural register of the pushed record |
| push_new | input | PHYS_W | Newly allocated physical register |
| push_prev | input | PHYS_W | Physical register previously mapped |
| full | output | 1 | No free slot; producer must stall |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Last surviving sequence number |
| flush | input | 1 | Undo every record |
| busy | output | 1 | A walk is in progress |
| map_wr_valid | output | 1 | Map restore write |
| map_wr_arch | output | ARCH_W | Architectural register to restore |
| map_wr_phys | output | PHYS_W | Physical register to write back |
| free_valid | output | 1 | Free-list return |
| free_phys | output | PHYS_W | Physical register returned |
| undo_count | output | CNT_W | Records undone since reset |
| commit_count | output | CNT_W | Records committed since reset |

## Verification
A wrong head or tail pointer shows up on the next walk. The map-restore or free outputs would carry the wrong register, or a record would be removed out of order, and this is visible one cycle after the faulty pop. A wrong occupancy count first shows at `full`, or as a walk that stops early or late. That shows up in `busy` and in the two counters within a cycle of the mistake. The bench compares every output against a queue model on every clock, so any such divergence is caught on the cycle it appears.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_SQUASH = 2'd1,
    WALK_FLUSH  = 2'd2,
    WALK_COMMIT = 2'd3
  } walk_e;
endpackage

// File: rtl/hb_store.sv
module hb_store #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [ARCH_W-1:0] push_arch,
  input  logic [PHYS_W-1:0] push_new,
  input  logic [PHYS_W-1:0] push_prev,
  input  logic              pop_old,
  input  logic              pop_young,
  output logic [SEQ_W-1:0]  old_seq,
  output logic [PHYS_W-1:0] old_prev,
  output logic [SEQ_W-1:0]  young_seq,
  output logic [ARCH_W-1:0] young_arch,
  output logic [PHYS_W-1:0] young_new,
  output logic [PHYS_W-1:0] young_prev,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] CAP  = OCC_W'(DEPTH);

  // Field-split storage: distributed RAM, one write port, two async reads
  logic [SEQ_W-1:0]  mem_seq  [DEPTH];
  logic [ARCH_W-1:0] mem_arch [DEPTH];
  logic [PHYS_W-1:0] mem_new  [DEPTH];
  logic [PHYS_W-1:0] mem_prev [DEPTH];

  logic [PTR_W-1:0] head_q, tail_q, young_idx;
  logic [OCC_W-1:0] occ_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_en) begin
      mem_seq[tail_q]  <= push_seq;
      mem_arch[tail_q] <= push_arch;
      mem_new[tail_q]  <= push_new;
      mem_prev[tail_q] <= push_prev;
    end
  end

  assign young_idx  = ptr_dec(tail_q);
  assign old_seq    = mem_seq[head_q];
  assign old_prev   = mem_prev[head_q];
  assign young_seq  = mem_seq[young_idx];
  assign young_arch = mem_arch[young_idx];
  assign young_new  = mem_new[young_idx];
  assign young_prev = mem_prev[young_idx];
  assign empty      = (occ_q == '0);
  assign full       = (occ_q == CAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (pop_old)
        head_q <= ptr_inc(head_q);
      if (push_en)
        tail_q <= ptr_inc(tail_q);
      else if (pop_young)
        tail_q <= young_idx;
      occ_q <= occ_q + OCC_W'(push_en) - OCC_W'(pop_old) - OCC_W'(pop_young);
    end
  end
endmodule

// File: rtl/hb_walk_ctrl.sv
module hb_walk_ctrl
  import hb_pkg::*;
#(
  parameter int SEQ_W  = 16,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              flush,
  input  logic              empty,
  input  logic              full,
  input  logic [SEQ_W-1:0]  old_seq,
  input  logic [PHYS_W-1:0] old_prev,
  input  logic [SEQ_W-1:0]  young_seq,
  input  logic [ARCH_W-1:0] young_arch,
  input  logic [PHYS_W-1:0] young_new,
  input  logic [PHYS_W-1:0] young_prev,
  output logic              push_en,
  output logic              pop_old,
  output logic              pop_young,
  output logic              busy,
  output logic              map_wr_valid,
  output logic [ARCH_W-1:0] map_wr_arch,
  output logic [PHYS_W-1:0] map_wr_phys,
  output logic              free_valid,
  output logic [PHYS_W-1:0] free_phys,
  output logic [CNT_W-1:0]  undo_count,
  output logic [CNT_W-1:0]  commit_count
);
  walk_e            mode_q, mode_d;
  logic [SEQ_W-1:0] target_q, target_d;
  logic             undoing;

  assign undoing = (mode_q == WALK_SQUASH) || (mode_q == WALK_FLUSH);
  assign busy    = (mode_q != WALK_IDLE);
  assign push_en = push_valid && !full && !flush && !squash_valid && !undoing;

  always_comb begin
    mode_d    = mode_q;
    target_d  = target_q;
    pop_old   = 1'b0;
    pop_young = 1'b0;
    unique case (mode_q)
      WALK_SQUASH: if (!empty && (young_seq > target_q)) pop_young = 1'b1;
                   else mode_d = WALK_IDLE;
      WALK_FLUSH:  if (!empty) pop_young = 1'b1;
                   else mode_d = WALK_IDLE;
      WALK_COMMIT: if (!empty && (old_seq <= target_q)) pop_old = 1'b1;
                   else mode_d = WALK_IDLE;
      default: ;
    endcase
    if (flush) begin
      mode_d = WALK_FLUSH;
    end else if (squash_valid && (mode_q != WALK_FLUSH)) begin
      mode_d   = WALK_SQUASH;
      target_d = squash_seq;
    end else if (commit_valid && !squash_valid && !undoing) begin
      mode_d   = WALK_COMMIT;
      target_d = commit_seq;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= WALK_IDLE;
      target_q     <= '0;
      map_wr_valid <= 1'b0;
      map_wr_arch  <= '0;
      map_wr_phys  <= '0;
      free_valid   <= 1'b0;
      free_phys    <= '0;
      undo_count   <= '0;
      commit_count <= '0;
    end else begin
      mode_q       <= mode_d;
      target_q     <= target_d;
      map_wr_valid <= pop_young;
      map_wr_arch  <= young_arch;
      map_wr_phys  <= young_prev;
      free_valid   <= pop_young || pop_old;
      free_phys    <= pop_young ? young_new : old_prev;
      undo_count   <= undo_count + CNT_W'(pop_young);
      commit_count <= commit_count + CNT_W'(pop_old);
    end
  end
endmodule

// File: rtl/rename_history.sv
module rename_history #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [ARCH_W-1:0] push_arch,
  input  logic [PHYS_W-1:0] push_new,
  input  logic [PHYS_W-1:0] push_prev,
  output logic              full,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              flush,
  output logic              busy,
  output logic              map_wr_valid,
  output logic [ARCH_W-1:0] map_wr_arch,
  output logic [PHYS_W-1:0] map_wr_phys,
  output logic              free_valid,
  output logic [PHYS_W-1:0] free_phys,
  output logic [CNT_W-1:0]  undo_count,
  output logic [CNT_W-1:0]  commit_count
);
  logic              push_en, pop_old, pop_young, empty;
  logic [SEQ_W-1:0]  old_seq, young_seq;
  logic [PHYS_W-1:0] old_prev, young_new, young_prev;
  logic [ARCH_W-1:0] young_arch;

  hb_store #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)
  ) store_i (
    .clk(clk), .rst(rst),
    .push_en(push_en), .push_seq(push_seq), .push_arch(push_arch),
    .push_new(push_new), .push_prev(push_prev),
    .pop_old(pop_old), .pop_young(pop_young),
    .old_seq(old_seq), .old_prev(old_prev),
    .young_seq(young_seq), .young_arch(young_arch),
    .young_new(young_new), .young_prev(young_prev),
    .empty(empty), .full(full)
  );

  hb_walk_ctrl #(
    .SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .push_valid(push_valid),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .flush(flush), .empty(empty), .full(full),
    .old_seq(old_seq), .old_prev(old_prev),
    .young_seq(young_seq), .young_arch(young_arch),
    .young_new(young_new), .young_prev(young_prev),
    .push_en(push_en), .pop_old(pop_old), .pop_young(pop_young),
    .busy(busy),
    .map_wr_valid(map_wr_valid), .map_wr_arch(map_wr_arch), .map_wr_phys(map_wr_phys),
    .free_valid(free_valid), .free_phys(free_phys),
    .undo_count(undo_count), .commit_count(commit_count)
  );
endmodule

// File: rtl/hb_checker.sv
module hb_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             squash_valid,
  input logic             flush,
  input logic             busy,
  input logic             full,
  input logic             map_wr_valid,
  input logic             free_valid,
  input logic [CNT_W-1:0] undo_count,
  input logic [CNT_W-1:0] commit_count
);
  AST_MAP_WITH_FREE: assert property (@(posedge clk) disable iff (rst)
    map_wr_valid |-> free_valid); // R2
  AST_OUT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    free_valid |-> $past(busy)); // R7
  AST_FLUSH_STARTS_WALK: assert property (@(posedge clk) disable iff (rst)
    flush |=> busy); // R6
  AST_SQUASH_STARTS_WALK: assert property (@(posedge clk) disable iff (rst)
    squash_valid |=> busy); // R7
  AST_UNDO_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    undo_count == $past(undo_count) + CNT_W'(map_wr_valid)); // R8
  AST_COMMIT_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    commit_count == $past(commit_count) + CNT_W'(free_valid && !map_wr_valid)); // R8
  AST_FULL_NOT_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
    (full && !busy) |=> !map_wr_valid); // R1
endmodule

bind rename_history hb_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .squash_valid(squash_valid), .flush(flush),
  .busy(busy), .full(full), .map_wr_valid(map_wr_valid), .free_valid(free_valid),
  .undo_count(undo_count), .commit_count(commit_count)
);

// File: tb/rename_history_tb_top.sv
module rename_history_tb_top;
  localparam int DEPTH = 16, SEQ_W = 16, ARCH_W = 5, PHYS_W = 7, CNT_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              push_valid = 0, commit_valid = 0, squash_valid = 0, flush = 0;
  logic [SEQ_W-1:0]  push_seq = 0, commit_seq = 0, squash_seq = 0;
  logic [ARCH_W-1:0] push_arch = 0;
  logic [PHYS_W-1:0] push_new = 0, push_prev = 0;
  logic              full, busy, map_wr_valid, free_valid;
  logic [ARCH_W-1:0] map_wr_arch;
  logic [PHYS_W-1:0] map_wr_phys, free_phys;
  logic [CNT_W-1:0]  undo_count, commit_count;

  rename_history #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W),
                   .PHYS_W(PHYS_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_seq(push_seq),
    .push_arch(push_arch), .push_new(push_new), .push_prev(push_prev), .full(full),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .flush(flush),
    .busy(busy), .map_wr_valid(map_wr_valid), .map_wr_arch(map_wr_arch),
    .map_wr_phys(map_wr_phys), .free_valid(free_valid), .free_phys(free_phys),
    .undo_count(undo_count), .commit_count(commit_count)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: queue of records, front is oldest
  typedef struct { int seq; int arch; int nw; int pv; } rec_t;
  typedef enum { M_IDLE, M_SQ, M_FL, M_CM } mmode_e;
  rec_t   q[$];
  mmode_e m_mode = M_IDLE;
  int     m_tgt = 0;
  bit     e_map_v = 0, e_free_v = 0;
  int     e_arch = 0, e_mphys = 0, e_fphys = 0, e_undo = 0, e_comm = 0;

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_mode = M_IDLE; m_tgt = 0;
      e_map_v = 0; e_free_v = 0; e_undo = 0; e_comm = 0;
    end else begin
      bit undo_act, push_ok;
      rec_t r;
      mmode_e nxt;
      undo_act = (m_mode == M_SQ) || (m_mode == M_FL);
      push_ok = push_valid && (q.size() < DEPTH) && !flush && !squash_valid && !undo_act;
      e_map_v = 0; e_free_v = 0;
      nxt = m_mode;
      if (m_mode == M_SQ || m_mode == M_FL) begin
        if (q.size() > 0 && (m_mode == M_FL || q[q.size()-1].seq > m_tgt)) begin
          r = q.pop_back();
          e_map_v = 1; e_free_v = 1;
          e_arch = r.arch; e_mphys = r.pv; e_fphys = r.nw; e_undo++;
        end else nxt = M_IDLE;
      end else if (m_mode == M_CM) begin
        if (q.size() > 0 && q[0].seq <= m_tgt) begin
          r = q.pop_front();
          e_free_v = 1; e_fphys = r.pv; e_comm++;
        end else nxt = M_IDLE;
      end
      if (flush) nxt = M_FL;
      else if (squash_valid && m_mode != M_FL) begin nxt = M_SQ; m_tgt = squash_seq; end
      else if (commit_valid && !undo_act) begin nxt = M_CM; m_tgt = commit_seq; end
      if (push_ok) q.push_back('{int'(push_seq), int'(push_arch), int'(push_new), int'(push_prev)});
      m_mode = nxt;
    end
  end

  // Compare on the falling edge, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1", "full", full, q.size() == DEPTH);
      chk("R7", "busy", busy, m_mode != M_IDLE);
      chk("R2", "map_wr_valid", map_wr_valid, e_map_v);
      if (e_map_v) begin
        chk("R2", "map_wr_arch", map_wr_arch, e_arch);
        chk("R2", "map_wr_phys", map_wr_phys, e_mphys);
      end
      chk(e_map_v ? "R2" : "R3", "free_valid", free_valid, e_free_v);
      if (e_free_v) chk(e_map_v ? "R2" : "R3", "free_phys", free_phys, e_fphys);
      chk("R8", "undo_count", undo_count, e_undo);
      chk("R8", "commit_count", commit_count, e_comm);
    end
  end

  task automatic step();
    @(negedge clk); #1;
    push_valid = 0; commit_valid = 0; squash_valid = 0; flush = 0;
  endtask

  task automatic do_push(int s, int a);
    push_valid = 1; push_seq = SEQ_W'(s); push_arch = ARCH_W'(a);
    push_new = PHYS_W'(32 + s % 90); push_prev = PHYS_W'(a + 1);
    step();
  endtask

  task automatic do_commit(int c);
    commit_valid = 1; commit_seq = SEQ_W'(c); step();
  endtask

  task automatic do_squash(int s);
    squash_valid = 1; squash_seq = SEQ_W'(s); step();
  endtask

  task automatic drain();
    for (int i = 0; i < 64 && busy; i++) step();
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R9: reset state
    chk("R9", "full", full, 0);
    chk("R9", "busy", busy, 0);
    chk("R9", "map_wr_valid", map_wr_valid, 0);
    chk("R9", "free_valid", free_valid, 0);
    chk("R9", "undo_count", undo_count, 0);
    chk("R9", "commit_count", commit_count, 0);
    rst = 0;
    step();
    // R1: pushes
    for (int i = 0; i < 5; i++) do_push(10 + i, i);
    // R3: commit up to 11 retires 10, 11
    do_commit(11); drain();
    chk("R3", "commit_count after commit 11", commit_count, 2);
    // R5: commit older than the oldest record
    do_commit(5); drain();
    chk("R5", "commit_count after stale commit", commit_count, 2);
    // R2: squash 12 undoes 14, 13
    do_squash(12); drain();
    chk("R2", "undo_count after squash 12", undo_count, 2);
    // R4: squash and commit in the same cycle
    do_push(20, 7); do_push(21, 8);
    squash_valid = 1; squash_seq = 21; commit_valid = 1; commit_seq = 20; step();
    drain();
    chk("R4", "commit_count with simultaneous squash", commit_count, 2);
    // R4: commit during a squash walk; push during walk rejected (R7)
    do_push(22, 9); do_push(23, 10);
    do_squash(20);
    commit_valid = 1; commit_seq = 30; push_valid = 1; push_seq = 24; step();
    drain();
    chk("R4", "commit_count during squash walk", commit_count, 2);
    chk("R2", "undo_count after squash 20", undo_count, 5);
    // R1: fill to capacity, then one dropped push
    for (int i = 0; i < 14; i++) do_push(40 + i, i % 32);
    chk("R1", "full at capacity", full, 1);
    do_push(99, 3);
    chk("R1", "full after dropped push", full, 1);
    // R6: flush undoes every record, pushes blocked while walking
    flush = 1; step();
    do_push(100, 4);
    drain();
    chk("R6", "undo_count after flush", undo_count, 21);
    chk("R6", "full after flush", full, 0);
    // R5: empty buffer ignores commit and squash
    do_commit(1000); drain();
    do_squash(0); drain();
    chk("R5", "commit_count on empty", commit_count, 2);
    chk("R5", "undo_count on empty", undo_count, 21);
    // R3: commit after refill
    do_push(60, 1); do_push(61, 2);
    do_commit(61); drain();
    chk("R3", "commit_count final", commit_count, 4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule